// File: doc/BRIEF.md
# Bit Set/Clear Alias Decoder

This unit sits on the write path in front of a small bank of peripheral registers. The same registers can be reached through three address windows. The normal window stores the write data as it is. The clear window drops every register bit where the write data holds a 1. The set window raises every register bit where the write data holds a 1. Each alias write is a masked update that completes inside the single bus access that carries it. The master never performs a read-modify-write, so any master on the bus can use it safely.

The register contents are presented on a flat output vector that drives the peripheral logic. A combinational read port returns the addressed register from any of the three windows. A per-register parameter mask marks registers that must not be changed through the alias windows. For such a register an alias write is silently dropped and raises no error.

Top module: `bsc_alias_top`

## Requirements
- R1: While `rst` is high, every register is loaded with `RESET_VAL` on each rising clock edge.
- R2: A write at `BASE_ADDR + 4*i` (normal window) replaces register i with `bus_wdata`. The new value is visible on `reg_q` after the rising edge on which `bus_we` was sampled high.
- R3: A write at `BASE_ADDR + 0x04000000 + 4*i` (clear window) sets register i to `old AND NOT bus_wdata` at that same edge.
- R4: A write at `BASE_ADDR + 0x06000000 + 4*i` (set window) sets register i to `old OR bus_wdata` at that same edge.
- R5: A write to register i leaves every other register unchanged.
- R6: When bit i of `NOALIAS_MASK` is 1, writes to register i through the clear or set window leave it unchanged. Normal-window writes still replace it.
- R7: While `bus_addr` hits any of the three windows, `bus_rdata` shows the current value of the addressed register in the same cycle.
- R8: An address outside all three windows, or one with `bus_addr[1:0]` not equal to 0, gives `bus_rdata` = 0, and a write to it changes no register.
- R9: No register changes on a clock edge at which `bus_we` is low and `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | DATA_W | Write data, used as a mask in the alias windows |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_rdata | output | DATA_W | Combinational read data |
| reg_q | output | NUM_REGS*DATA_W | Register contents, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench builds the block with 8-bit registers, four registers, a non-zero reset pattern, and register 2 marked as protected from aliasing. With 8-bit data, every one of the 256 write values can be driven to every register through each of the three windows. The expected results come from plain OR and AND-NOT arithmetic. Having four registers including one protected register means that each sweep step also confirms that the untouched registers and the protected register hold their values. The window edges are probed directly: one word past the end, one word before the start, and misaligned byte offsets.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned N_WIN  = 3;

    localparam logic [ADDR_W-1:0] CLR_ALIAS_OFS = 32'h0400_0000;
    localparam logic [ADDR_W-1:0] SET_ALIAS_OFS = 32'h0600_0000;

    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,
        VIEW_NORM = 2'd1,
        VIEW_CLR  = 2'd2,
        VIEW_SET  = 2'd3
    } view_e;

    typedef struct packed {
        logic  hit;
        view_e view;
    } win_sel_t;

    function automatic logic [ADDR_W-1:0] win_ofs(input int v);
        case (v)
            1:       return CLR_ALIAS_OFS;
            2:       return SET_ALIAS_OFS;
            default: return '0;
        endcase
    endfunction

    function automatic view_e win_view(input int v);
        case (v)
            0:       return VIEW_NORM;
            1:       return VIEW_CLR;
            default: return VIEW_SET;
        endcase
    endfunction

endpackage

// File: rtl/bsc_window_match.sv
module bsc_window_match #(
    parameter logic [31:0] WIN_BASE = 32'h0,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [31:0] SPAN = 32'(NUM_REGS * 4);

    logic [31:0] off;

    always_comb begin
        off = addr - WIN_BASE;
        hit = (off < SPAN) && (off[1:0] == 2'b00);
        idx = off[IDX_W+1:2];
    end

endmodule

// File: rtl/bsc_addr_decode.sv
module bsc_addr_decode
    import bsc_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic [31:0]      addr,
    output win_sel_t         sel,
    output logic [IDX_W-1:0] idx
);
    logic [N_WIN-1:0] w_hit;
    logic [IDX_W-1:0] w_idx [N_WIN];

    for (genvar v = 0; v < N_WIN; v++) begin : g_win
        bsc_window_match #(
            .WIN_BASE (BASE_ADDR + win_ofs(v)),
            .NUM_REGS (NUM_REGS),
            .IDX_W    (IDX_W)
        ) u_match (
            .addr (addr),
            .hit  (w_hit[v]),
            .idx  (w_idx[v])
        );
    end

    always_comb begin
        sel.hit  = 1'b0;
        sel.view = VIEW_NONE;
        idx      = '0;
        for (int v = N_WIN - 1; v >= 0; v--) begin
            if (w_hit[v]) begin
                sel.hit  = 1'b1;
                sel.view = win_view(v);
                idx      = w_idx[v];
            end
        end
    end

endmodule

// File: rtl/bsc_reg_cell.sv
module bsc_reg_cell
    import bsc_pkg::*;
#(
    parameter int unsigned       DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '0,
    parameter bit                ALIAS_OK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  view_e             view,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
        q_nxt = q;
        if (wr_en) begin
            case (view)
                VIEW_NORM: q_nxt = wdata;
                VIEW_CLR:  if (ALIAS_OK) q_nxt = q & ~wdata;
                VIEW_SET:  if (ALIAS_OK) q_nxt = q | wdata;
                default:   q_nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= q_nxt;
    end

endmodule

// File: rtl/bsc_alias_top.sv
module bsc_alias_top
    import bsc_pkg::*;
#(
    parameter int unsigned         DATA_W       = 32,
    parameter int unsigned         NUM_REGS     = 16,
    parameter logic [31:0]         BASE_ADDR    = 32'h4000_0000,
    parameter logic [NUM_REGS-1:0] NOALIAS_MASK = '0,
    parameter logic [DATA_W-1:0]   RESET_VAL    = '0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [31:0]                  bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic                         bus_we,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0]   reg_q
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    win_sel_t          sel;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] q_arr [NUM_REGS];

    bsc_addr_decode #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic wr_en;
        assign wr_en = bus_we && sel.hit && (idx == IDX_W'(i));

        bsc_reg_cell #(
            .DATA_W    (DATA_W),
            .RESET_VAL (RESET_VAL),
            .ALIAS_OK  (!NOALIAS_MASK[i])
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .view  (sel.view),
            .wdata (bus_wdata),
            .q     (q_arr[i])
        );

        assign reg_q[i*DATA_W +: DATA_W] = q_arr[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.hit) bus_rdata = q_arr[idx];
    end

endmodule

// File: rtl/bsc_alias_chk.sv
module bsc_alias_chk #(
    parameter int unsigned         DATA_W       = 32,
    parameter int unsigned         NUM_REGS     = 16,
    parameter logic [31:0]         BASE_ADDR    = 32'h4000_0000,
    parameter logic [NUM_REGS-1:0] NOALIAS_MASK = '0
) (
    input logic                       clk,
    input logic                       rst,
    input logic [31:0]                bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_we,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_REGS*DATA_W-1:0] reg_q
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [31:0] SPAN  = 32'(NUM_REGS * 4);

    logic [31:0] o_n, o_c, o_s;
    logic        h_n, h_c, h_s, any_hit, ok_alias;
    logic [IDX_W-1:0] c_idx, idx_q;
    logic [DATA_W-1:0] cur, tgt_q;

    always_comb begin
        o_n = bus_addr - BASE_ADDR;
        o_c = bus_addr - (BASE_ADDR + 32'h0400_0000);
        o_s = bus_addr - (BASE_ADDR + 32'h0600_0000);
        h_n = (o_n < SPAN) && (o_n[1:0] == 2'b00);
        h_c = (o_c < SPAN) && (o_c[1:0] == 2'b00);
        h_s = (o_s < SPAN) && (o_s[1:0] == 2'b00);
        any_hit = h_n || h_c || h_s;
        c_idx = h_n ? o_n[IDX_W+1:2] : (h_c ? o_c[IDX_W+1:2] : o_s[IDX_W+1:2]);
        ok_alias = !NOALIAS_MASK[c_idx];
        cur   = reg_q[int'(c_idx)*DATA_W +: DATA_W];
        tgt_q = reg_q[int'(idx_q)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= c_idx;
    end

    assert_normal_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && h_n) |=> (tgt_q == $past(bus_wdata)));

    assert_clear_view_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && h_c && ok_alias) |=> (tgt_q == ($past(cur) & ~$past(bus_wdata))));

    assert_set_view_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && h_s && ok_alias) |=> (tgt_q == ($past(cur) | $past(bus_wdata))));

    assert_protected_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (h_c || h_s) && !h_n && !ok_alias) |=> $stable(reg_q));

    assert_read_view_R7: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (bus_rdata == cur));

    assert_outside_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !any_hit) |=> $stable(reg_q));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(reg_q));

endmodule

bind bsc_alias_top bsc_alias_chk #(
    .DATA_W       (DATA_W),
    .NUM_REGS     (NUM_REGS),
    .BASE_ADDR    (BASE_ADDR),
    .NOALIAS_MASK (NOALIAS_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .reg_q     (reg_q)
);

// File: tb/tb_bsc_alias_top.sv
module tb_bsc_alias_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          DW   = 8;
    localparam int          NR   = 4;
    localparam logic [31:0] BASE = 32'h4000_1000;
    localparam logic [NR-1:0] PROT = 4'b0100;
    localparam logic [DW-1:0] RV   = 8'h5A;
    localparam logic [31:0] CLR_OFS = 32'h0400_0000;
    localparam logic [31:0] SET_OFS = 32'h0600_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [DW-1:0]     bus_rdata;
    logic [NR*DW-1:0]  reg_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_r [NR];

    bsc_alias_top #(
        .DATA_W       (DW),
        .NUM_REGS     (NR),
        .BASE_ADDR    (BASE),
        .NOALIAS_MASK (PROT),
        .RESET_VAL    (RV)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .reg_q     (reg_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] win_addr(input int w, input int r);
        logic [31:0] o;
        o = (w == 1) ? CLR_OFS : ((w == 2) ? SET_OFS : 32'h0);
        return BASE + o + 32'(r * 4);
    endfunction

    task automatic check_val(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NR; i++)
            check_val(req, reg_q[i*DW +: DW], exp_r[i]);
    endtask

    // write: inputs set after a falling edge, sampled at the next rising edge
    task automatic do_write(input logic [31:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        #1;
    endtask

    task automatic read_check(input string req, input logic [31:0] a, input logic [DW-1:0] expv);
        bus_addr = a;
        #1;
        check_val(req, bus_rdata, expv);
    endtask

    task automatic model_win(input int w, input int r, input logic [DW-1:0] d);
        if (w == 0)             exp_r[r] = d;
        else if (PROT[r])       exp_r[r] = exp_r[r];
        else if (w == 1)        exp_r[r] = exp_r[r] & ~d;
        else                    exp_r[r] = exp_r[r] | d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) exp_r[i] = RV;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset value");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R1 after release");

        // sweep: every data value through every window on every register
        for (int r = 0; r < NR; r++) begin
            for (int m = 0; m < 256; m++) begin
                logic [DW-1:0] d0, d1, d2;
                d0 = DW'(m);
                d1 = DW'(m * 7 + 3);
                d2 = DW'(m * 13 + 5);
                do_write(win_addr(0, r), d0);
                model_win(0, r, d0);
                check_all("R2 normal write / R5 others");
                do_write(win_addr(2, r), d1);
                model_win(2, r, d1);
                check_all(PROT[r] ? "R6 set on protected" : "R4 set view / R5 others");
                read_check("R7 read set view", win_addr(2, r), exp_r[r]);
                do_write(win_addr(1, r), d2);
                model_win(1, r, d2);
                check_all(PROT[r] ? "R6 clear on protected" : "R3 clear view / R5 others");
                read_check("R7 read clear view", win_addr(1, r), exp_r[r]);
                read_check("R7 read normal view", win_addr(0, r), exp_r[r]);
            end
        end

        // give each register a distinct value
        for (int r = 0; r < NR; r++) begin
            do_write(win_addr(0, r), DW'(8'h11 * (r + 1)));
            model_win(0, r, DW'(8'h11 * (r + 1)));
        end
        check_all("R2 distinct values");

        // window edges and misaligned offsets
        for (int w = 0; w < 3; w++) begin
            do_write(win_addr(w, NR), 8'hFF);
            check_all("R8 write past end");
            read_check("R8 read past end", win_addr(w, NR), 8'h00);
            do_write(win_addr(w, 0) - 32'd4, 8'h00);
            check_all("R8 write before start");
            read_check("R8 read before start", win_addr(w, 0) - 32'd4, 8'h00);
            for (int b = 1; b < 4; b++) begin
                do_write(win_addr(w, 1) + 32'(b), 8'hC3);
                check_all("R8 misaligned write");
                read_check("R8 misaligned read", win_addr(w, 1) + 32'(b), 8'h00);
            end
        end

        // idle: address and data move with write strobe low
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            bus_addr  = win_addr(k % 3, k % NR);
            bus_wdata = DW'(k * 29 + 1);
            @(negedge clk);
        end
        #1;
        check_all("R9 idle hold");

        // second reset in mid run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        for (int i = 0; i < NR; i++) exp_r[i] = RV;
        check_all("R1 mid-run reset");
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule